// File: doc/BRIEF.md
# UART receive event status register

This block gathers the sticky event flags of a UART receiver into one 32-bit status word. The receive path reports its events as single-cycle pulses: control or address character seen, programmed character match, end of break, start of break, framing error, parity error and overrun. Each pulse sets its own bit. The bit stays set until software reads it away. Bit 0 is different. It tracks a level from the receive FIFO, which is high while the fill level is above the programmed threshold. Software acknowledges bit 0 by writing a zero to it, and the bit is forced low during any FIFO read access.

A second register on the same bus shows a line-status view of the lower five bits. That view has no storage of its own, so reading either register clears the shared event bits in both. A third register holds an 8-bit enable mask. The single interrupt output is the OR of all status bits that are enabled. The register port is a plain strobe-based bus: a read strobe returns data on the cycle after the strobe, and a write strobe takes effect at the same clock edge. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `rx_evt_status`

## Requirements
- R1: After reset, reads of the status register (address 0), the line-status view (address 1) and the enable mask (address 2) all return zero, and `irq` is low.
- R2: A pulse on an event input sets its status bit at the next clock edge, and the bit stays set until a clearing read. The bit positions are: character bit 7, match bit 6, break end bit 5, break start bit 4, framing bit 3, parity bit 2, overrun bit 1.
- R3: A read of address 0 returns the status in bits 7:0 of `reg_rdata` on the next cycle, with bits 31:8 zero. The same read clears bits 7:1 in both views.
- R4: A read of address 1 returns status bits 4:0 in bits 4:0 of `reg_rdata`, with all higher bits zero. The same read clears status bits 4:1 and leaves bits 7:5 untouched.
- R5: If an event pulse arrives in the same cycle as a clearing read, the read returns the old value, and the bit is set after the read.
- R6: Bit 0 is set one cycle after `fifo_above_thr` goes high. Reads of address 0 or address 1 do not clear it.
- R7: A cycle with `fifo_rd` high leaves bit 0 low after that edge. Bit 0 is set again one cycle later if the level is still high and no acknowledge is pending.
- R8: Writing 0 to bit 0 of address 0 clears bit 0, and the bit stays low until `fifo_above_thr` has been low for at least one cycle. Writing 1 to bit 0 has no effect, and written values of bits 7:1 are ignored.
- R9: `irq` is high exactly when some status bit is set and its bit in the enable mask is also set. The mask is written at address 2, only bits 7:0 are kept, and the mask reads back at address 2.
- R10: Address 3 reads as zero, and a write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| ev_ctrl_char | input | 1 | Control/address character pulse |
| ev_prog_match | input | 1 | Programmed character match pulse |
| ev_brk_end | input | 1 | Break ended pulse |
| ev_brk_start | input | 1 | Break started pulse |
| ev_frame_err | input | 1 | Missing stop bit pulse |
| ev_par_err | input | 1 | Parity error pulse |
| ev_overrun | input | 1 | Character lost, FIFO full |
| fifo_above_thr | input | 1 | FIFO level above threshold |
| fifo_rd | input | 1 | FIFO read access in progress |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong sticky bit can be seen on `irq` on the cycle after the edge that corrupted it, provided the bit is enabled. It also shows up on the data returned by the next read. A clear that went wrong shows up as a stale value on the second of two back-to-back reads. It also shows up as a stale value across the two register views. A fault in the FIFO request logic shows up on `irq` within one cycle of a FIFO read, a zero-write or a change of the level.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int BIT_FIFO   = 0;
  localparam int BIT_OVR    = 1;
  localparam int BIT_PAR    = 2;
  localparam int BIT_FRM    = 3;
  localparam int BIT_BRKS   = 4;
  localparam int BIT_BRKE   = 5;
  localparam int BIT_PMATCH = 6;
  localparam int BIT_CTRL   = 7;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_LINE = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rxs_bus_dec.sv
module rxs_bus_dec #(
  parameter int ADDR_W   = 2,
  parameter int N_EVT    = 7,
  parameter int SHARED_W = 5
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              wdata_b0,
  output logic [N_EVT-1:0]  evt_clr,
  output logic              ack_wr,
  output logic              mask_we,
  output rxs_pkg::reg_sel_e rd_sel
);
  import rxs_pkg::*;

  logic rd_stat, rd_line;

  always_comb begin
    case (reg_addr)
      2'd0:    rd_sel = SEL_STAT;
      2'd1:    rd_sel = SEL_LINE;
      2'd2:    rd_sel = SEL_MASK;
      default: rd_sel = SEL_NONE;
    endcase
  end

  assign rd_stat = reg_rd && (rd_sel == SEL_STAT);
  assign rd_line = reg_rd && (rd_sel == SEL_LINE);
  assign ack_wr  = reg_wr && (rd_sel == SEL_STAT) && !wdata_b0;
  assign mask_we = reg_wr && (rd_sel == SEL_MASK);

  // event bit i sits at status bit i+1; shared view covers status bits below SHARED_W
  for (genvar i = 0; i < N_EVT; i++) begin : g_clr
    if (i + 1 < SHARED_W) begin : g_shared
      assign evt_clr[i] = rd_stat | rd_line;
    end else begin : g_private
      assign evt_clr[i] = rd_stat;
    end
  end
endmodule

// File: rtl/rxs_evt_latch.sv
module rxs_evt_latch #(
  parameter int N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [N_EVT-1:0] evt_clr,
  output logic [N_EVT-1:0] evt_q
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[i] <= 1'b0;
      else        evt_q[i] <= (evt_q[i] & ~evt_clr[i]) | evt_pulse[i];
    end
  end
endmodule

// File: rtl/rxs_fifo_req.sv
module rxs_fifo_req (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_above_thr,
  input  logic fifo_rd,
  input  logic ack_wr,
  output logic req_q
);
  logic ack_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_pend_q <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      if (ack_wr)               ack_pend_q <= 1'b1;
      else if (!fifo_above_thr) ack_pend_q <= 1'b0;
      req_q <= fifo_above_thr && !fifo_rd && !ack_wr && !ack_pend_q;
    end
  end
endmodule

// File: rtl/rxs_irq_gen.sv
module rxs_irq_gen #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign irq = |(stat & mask_q);
endmodule

// File: rtl/rxs_rd_port.sv
module rxs_rd_port #(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 8,
  parameter int SHARED_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  rxs_pkg::reg_sel_e rd_sel,
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] mask,
  output logic [DATA_W-1:0] rdata_q
);
  import rxs_pkg::*;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (reg_rd) begin
      case (rd_sel)
        SEL_STAT: rdata_d[STAT_W-1:0]   = stat;
        SEL_LINE: rdata_d[SHARED_W-1:0] = stat[SHARED_W-1:0];
        SEL_MASK: rdata_d[STAT_W-1:0]   = mask;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/rx_evt_status.sv
module rx_evt_status #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int N_EVT    = 7,
  parameter int SHARED_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_ctrl_char,
  input  logic              ev_prog_match,
  input  logic              ev_brk_end,
  input  logic              ev_brk_start,
  input  logic              ev_frame_err,
  input  logic              ev_par_err,
  input  logic              ev_overrun,
  input  logic              fifo_above_thr,
  input  logic              fifo_rd,
  output logic              irq
);
  import rxs_pkg::*;

  localparam int STAT_W = N_EVT + 1;

  logic [N_EVT-1:0]  ev_vec;
  logic [N_EVT-1:0]  evt_clr;
  logic [N_EVT-1:0]  evt_q;
  logic              req_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  logic              ack_wr, mask_we;
  reg_sel_e          rd_sel;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:STAT_W];

  assign ev_vec[BIT_OVR-1]    = ev_overrun;
  assign ev_vec[BIT_PAR-1]    = ev_par_err;
  assign ev_vec[BIT_FRM-1]    = ev_frame_err;
  assign ev_vec[BIT_BRKS-1]   = ev_brk_start;
  assign ev_vec[BIT_BRKE-1]   = ev_brk_end;
  assign ev_vec[BIT_PMATCH-1] = ev_prog_match;
  assign ev_vec[BIT_CTRL-1]   = ev_ctrl_char;

  assign stat_q = {evt_q, req_q};

  rxs_bus_dec #(.ADDR_W(ADDR_W), .N_EVT(N_EVT), .SHARED_W(SHARED_W)) u_dec (
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .wdata_b0(reg_wdata[BIT_FIFO]), .evt_clr(evt_clr), .ack_wr(ack_wr),
    .mask_we(mask_we), .rd_sel(rd_sel)
  );

  rxs_evt_latch #(.N_EVT(N_EVT)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_pulse(ev_vec), .evt_clr(evt_clr), .evt_q(evt_q)
  );

  rxs_fifo_req u_req (
    .clk(clk), .rst_n(rst_n), .fifo_above_thr(fifo_above_thr),
    .fifo_rd(fifo_rd), .ack_wr(ack_wr), .req_q(req_q)
  );

  rxs_irq_gen #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we),
    .mask_wdata(reg_wdata[STAT_W-1:0]), .stat(stat_q), .mask_q(mask_q), .irq(irq)
  );

  rxs_rd_port #(.DATA_W(DATA_W), .STAT_W(STAT_W), .SHARED_W(SHARED_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .rd_sel(rd_sel),
    .stat(stat_q), .mask(mask_q), .rdata_q(reg_rdata)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int N_EVT  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [N_EVT-1:0]  ev_vec,
  input logic              fifo_above_thr,
  input logic              fifo_rd,
  input logic [N_EVT:0]    stat,
  input logic [N_EVT:0]    mask,
  input logic              irq,
  input logic [DATA_W-1:0] reg_rdata
);
  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != '0) |=> ((stat[N_EVT:1] & $past(ev_vec)) == $past(ev_vec)));

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> ((stat[N_EVT:1] & $past(stat[N_EVT:1])) == $past(stat[N_EVT:1])));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == '0 && ev_vec == '0) |=> (stat[N_EVT:1] == '0));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:N_EVT+1] == '0);

  assert_level_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_above_thr |=> !stat[0]);

  assert_fifo_rd_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !stat[0]);

  assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind rx_evt_status rxs_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .ev_vec(ev_vec),
  .fifo_above_thr(fifo_above_thr), .fifo_rd(fifo_rd), .stat(stat_q), .mask(mask_q),
  .irq(irq), .reg_rdata(reg_rdata)
);

// File: tb/sim_rx_evt_status.sv
module sim_rx_evt_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:1]  ev = '0;
  logic        fifo_above_thr = 1'b0, fifo_rd = 1'b0;
  logic        irq;
  logic        rd_d = 1'b0;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_item_t;
  exp_item_t sb[$];

  always #4 clk = ~clk;

  rx_evt_status u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_ctrl_char(ev[7]), .ev_prog_match(ev[6]), .ev_brk_end(ev[5]),
    .ev_brk_start(ev[4]), .ev_frame_err(ev[3]), .ev_par_err(ev[2]),
    .ev_overrun(ev[1]), .fifo_above_thr(fifo_above_thr), .fifo_rd(fifo_rd), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= reg_rd;

  // monitor: compares read data one cycle after each read strobe
  always @(negedge clk) begin
    if (rd_d && rst_n) begin
      if (sb.size() == 0) chk(reg_rdata, 32'hx, "scoreboard underflow");
      else begin
        exp_item_t it;
        it = sb.pop_front();
        chk(reg_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    sb.push_back('{exp, tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_pulse(input logic [1:0] a, input logic [31:0] exp, input string tag,
                          input logic [7:0] m);
    reg_addr = a; reg_rd = 1'b1; ev = m[7:1];
    sb.push_back('{exp, tag});
    @(negedge clk);
    reg_rd = 1'b0; ev = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    ev = m[7:1];
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1 irq after reset");
    rd(2'd0, 32'h0, "R1 status after reset");
    rd(2'd1, 32'h0, "R1 line view after reset");
    rd(2'd2, 32'h0, "R1 mask after reset");
    // R2 / R3 set and clear-on-read
    pulse(8'h08);
    @(negedge clk);
    rd(2'd0, 32'h08, "R2 framing bit sticky");
    rd(2'd0, 32'h00, "R3 cleared by status read");
    // R4 line view clears shared bits only
    pulse(8'hA2);
    rd(2'd1, 32'h02, "R4 line view shows overrun");
    rd(2'd0, 32'hA0, "R4 bits 7:5 kept after line read");
    pulse(8'h14);
    rd(2'd0, 32'h14, "R3 break start and parity");
    rd(2'd1, 32'h00, "R3 status read cleared line view");
    // R5 collision
    rd_pulse(2'd0, 32'h00, "R5 read returns old value", 8'h40);
    rd(2'd0, 32'h40, "R5 match bit kept");
    rd_pulse(2'd1, 32'h00, "R5 line read returns old value", 8'h04);
    rd(2'd0, 32'h04, "R5 parity bit kept");
    // R6 FIFO level
    wr(2'd2, 32'h01);
    fifo_above_thr = 1'b1;
    @(negedge clk);
    chk({31'b0, irq}, 32'h1, "R6 bit0 follows level");
    rd(2'd0, 32'h01, "R6 bit0 read");
    rd(2'd0, 32'h01, "R6 bit0 not cleared by status read");
    rd(2'd1, 32'h01, "R6 bit0 in line view");
    rd(2'd1, 32'h01, "R6 bit0 not cleared by line read");
    // R7 FIFO read forces low
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
    chk({31'b0, irq}, 32'h0, "R7 low after fifo read");
    @(negedge clk);
    chk({31'b0, irq}, 32'h1, "R7 reasserts");
    // R8 acknowledge
    wr(2'd0, 32'h0);
    chk({31'b0, irq}, 32'h0, "R8 ack clears bit0");
    repeat (3) @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R8 ack holds while level high");
    fifo_above_thr = 1'b0;
    @(negedge clk);
    fifo_above_thr = 1'b1;
    @(negedge clk);
    chk({31'b0, irq}, 32'h1, "R8 rearmed after level drop");
    wr(2'd0, 32'hFF);
    chk({31'b0, irq}, 32'h1, "R8 writing one no effect");
    pulse(8'h80);
    wr(2'd0, 32'hFF);
    rd(2'd0, 32'h81, "R8 write ignored on bits 7:1");
    rd(2'd0, 32'h01, "R3 bit7 cleared, bit0 kept");
    fifo_above_thr = 1'b0;
    @(negedge clk);
    // R9 mask and irq
    wr(2'd2, 32'hFFFF_FF08);
    rd(2'd2, 32'h08, "R9 mask readback low bits only");
    pulse(8'h80);
    chk({31'b0, irq}, 32'h0, "R9 disabled bit no irq");
    pulse(8'h08);
    chk({31'b0, irq}, 32'h1, "R9 enabled bit raises irq");
    rd(2'd0, 32'h88, "R9 status before clear");
    chk({31'b0, irq}, 32'h0, "R9 irq drops after clear");
    // R10 unmapped address
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R10 unmapped reads zero");
    rd(2'd2, 32'h08, "R10 write did not touch mask");
    rd(2'd0, 32'h00, "R10 write did not touch status");
    repeat (2) @(negedge clk);
    if (sb.size() != 0) chk(32'(sb.size()), 32'h0, "scoreboard leftover");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule